// File: doc/BRIEF.md
# Token-Chain Addressed Line Buffer

This block stores one row of display cells: forty words, each holding a character code and a colour nibble. No binary address selects a word. A one-hot token enters at word 0 when a start strobe arrives and then moves one word further on every clock until it falls off the far end. Nothing can stop or recall a token once it is running. Whatever word the token is on is the word that a fetch line writes and that an active display line reads.

A start strobe that arrives while an earlier token is still moving adds a second token, so two or more words can be selected in the same cycle. The block resolves this case the same way every time. A read of several words returns their bitwise AND, because a 0 always wins a bitline. That read also writes the AND value back into every selected word. A write puts the same data into every selected word. The corruption that follows from a stray restart can therefore be reproduced exactly.

Top module: `lbuf_token_buffer`

## Requirements
- R1: Each stored word is 12 bits wide. The colour nibble is bits 11:8 and the character code is bits 7:0. A word that is written and later read alone comes back with all 12 bits unchanged.
- R2: A start strobe sampled high at a clock edge puts a token on word 0 for the next cycle. A token moves from word k to word k+1 at every clock, so word k is selected k+1 cycles after the strobe. A token on word 39 is dropped at the next edge.
- R3: A strobe issued while other tokens are moving adds a new token at word 0 and leaves the existing tokens where they are. All words that hold a token are selected at once.
- R4: When the fetch write enable is high and at least one word is selected, every selected word takes the 12-bit write data at that edge. Words that are not selected keep their contents.
- R5: When display is enabled, the write enable is low and at least one word is selected, the read data in the next cycle is the bitwise AND of all selected words.
- R6: A display read with two or more selected words overwrites each selected word with that AND value. A display read with one selected word leaves that word unchanged.
- R7: With no word selected, a write has no effect on storage. A display read then returns all ones (0xFFF) in the next cycle.
- R8: With display disabled, the read data in the next cycle is 0xFFF. Writes still take effect.
- R9: When write and display are both active on selected words in the same cycle, the read data in the next cycle equals the write data, and the selected words take the write data with no AND overwrite.
- R10: A synchronous reset removes every token and sets the read data to 0xFFF. It leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears tokens only |
| chain_start | input | 1 | Start strobe; injects a token at word 0 |
| fetch_we | input | 1 | Write enable for fetch lines |
| fetch_word | input | 12 | Write data: {colour[3:0], char[7:0]} |
| show_en | input | 1 | Display-active enable; turns on reads |
| rd_word | output | 12 | Registered read data |

## Verification
A write and a display read can happen in the same cycle. Either one can also meet a multi-token selection. The bench provokes the first case with directed passes that hold both enables high while a token sweeps the row. It provokes the second with a strobe placed part way through a sweep, and with random strobes laid over random enables. A reference model in the bench judges every cycle. It tracks its own token vector and storage, lets write win over the AND write-back, and is then compared with the read data and with clean readback passes taken afterwards.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

  // What the storage array does in a given cycle
  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,  // no token anywhere
    ACC_HOLD  = 3'd1,  // tokens present, neither write nor display
    ACC_WRITE = 3'd2,  // fetch write to all selected words
    ACC_READ  = 3'd3,  // single-word display read
    ACC_FLIP  = 3'd4   // multi-word display read with AND write-back
  } acc_kind_t;

  // Write wins over a read on the same bitlines
  function automatic acc_kind_t acc_decide(input logic any_sel,
                                           input logic multi_sel,
                                           input logic we,
                                           input logic show);
    acc_kind_t k;
    if (!any_sel)       k = ACC_NONE;
    else if (we)        k = ACC_WRITE;
    else if (!show)     k = ACC_HOLD;
    else if (multi_sel) k = ACC_FLIP;
    else                k = ACC_READ;
    return k;
  endfunction

  // True when a one-hot-or-more vector has at least two bits set
  function automatic logic more_than_one(input logic [63:0] v);
    return (v & (v - 64'd1)) != 64'd0;
  endfunction

endpackage

// File: rtl/lbuf_token_chain.sv
module lbuf_token_chain #(
  parameter int DEPTH = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic [DEPTH-1:0] tok_o,
  output logic             any_o,
  output logic             multi_o
);
  import lbuf_pkg::*;

  logic [DEPTH-1:0] tok_q;
  logic [DEPTH-1:0] tok_d;
  logic [63:0]      tok_wide;

  // Shift toward the far end; the token on the last word drops out
  always_comb begin
    tok_d    = {tok_q[DEPTH-2:0], 1'b0};
    tok_d[0] = start_i;
  end

  always_ff @(posedge clk) begin
    if (rst) tok_q <= '0;
    else     tok_q <= tok_d;
  end

  assign tok_wide = 64'(tok_q);
  assign tok_o    = tok_q;
  assign any_o    = |tok_q;
  assign multi_o  = more_than_one(tok_wide);

  AST_TOKEN_ENTRY: assert property (@(posedge clk) disable iff (rst) start_i |=> tok_q[0]); // R2
  AST_TOKEN_SHIFT: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> tok_q[DEPTH-1:1] == $past(tok_q[DEPTH-2:0])); // R3
  AST_MULTI_COUNT: assert property (@(posedge clk) disable iff (rst) multi_o == ($countones(tok_q) > 1)); // R3

endmodule

// File: rtl/lbuf_cell_array.sv
module lbuf_cell_array
  import lbuf_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEPTH-1:0]  tok_i,
  input  acc_kind_t         acc_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] and_o
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] bitline;

  // Precharged bitlines: ones unless a selected cell pulls a bit to 0
  always_comb begin
    bitline = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (tok_i[i]) bitline = bitline & mem[i];
    end
  end
  assign and_o = bitline;

  // Storage holds its contents across reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (tok_i[i]) begin
        if (acc_i == ACC_WRITE)     mem[i] <= wdata_i;
        else if (acc_i == ACC_FLIP) mem[i] <= bitline;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst) (acc_i == ACC_WRITE && tok_i[g]) |=> mem[g] == $past(wdata_i)); // R4
    AST_FLIP_SETTLES: assert property (@(posedge clk) disable iff (rst) (acc_i == ACC_FLIP && tok_i[g]) |=> mem[g] == $past(and_o)); // R6
    AST_UNSELECTED_KEEP: assert property (@(posedge clk) disable iff (rst) !tok_i[g] |=> $stable(mem[g])); // R4
  end

endmodule

// File: rtl/lbuf_sense.sv
module lbuf_sense
  import lbuf_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              show_i,
  input  acc_kind_t         acc_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] and_i,
  output logic [WORD_W-1:0] rd_o
);

  logic [WORD_W-1:0] sensed;

  always_comb begin
    if (!show_i)                 sensed = '1;
    else if (acc_i == ACC_WRITE) sensed = wdata_i;
    else                         sensed = and_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_o <= '1;
    else     rd_o <= sensed;
  end

  AST_AND_NO_RISE: assert property (@(posedge clk) disable iff (rst) (show_i && (acc_i == ACC_READ || acc_i == ACC_FLIP)) |=> (rd_o & ~$past(and_i)) == '0); // R5

endmodule

// File: rtl/lbuf_token_buffer.sv
module lbuf_token_buffer
  import lbuf_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int CHAR_W = 8,
  parameter int COL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chain_start,
  input  logic                    fetch_we,
  input  logic [CHAR_W+COL_W-1:0] fetch_word,
  input  logic                    show_en,
  output logic [CHAR_W+COL_W-1:0] rd_word
);
  localparam int WORD_W = CHAR_W + COL_W;

  logic [DEPTH-1:0]  tok;
  logic              any_sel;
  logic              multi_sel;
  acc_kind_t         acc;
  logic [WORD_W-1:0] and_val;

  // Named events for the checks
  logic wr_fire;
  logic rd_fire;
  logic flip_fire;

  lbuf_token_chain #(.DEPTH(DEPTH)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .start_i (chain_start),
    .tok_o   (tok),
    .any_o   (any_sel),
    .multi_o (multi_sel)
  );

  assign acc       = acc_decide(any_sel, multi_sel, fetch_we, show_en);
  assign wr_fire   = (acc == ACC_WRITE);
  assign rd_fire   = (acc == ACC_READ) || (acc == ACC_FLIP);
  assign flip_fire = (acc == ACC_FLIP);

  lbuf_cell_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_cells (
    .clk     (clk),
    .rst     (rst),
    .tok_i   (tok),
    .acc_i   (acc),
    .wdata_i (fetch_word),
    .and_o   (and_val)
  );

  lbuf_sense #(.WORD_W(WORD_W)) u_sense (
    .clk     (clk),
    .rst     (rst),
    .show_i  (show_en),
    .acc_i   (acc),
    .wdata_i (fetch_word),
    .and_i   (and_val),
    .rd_o    (rd_word)
  );

  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (rst) (show_en && !any_sel) |=> rd_word == '1); // R7
  AST_DARK_ONES: assert property (@(posedge clk) disable iff (rst) !show_en |=> rd_word == '1); // R8
  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (rst) (show_en && wr_fire) |=> rd_word == $past(fetch_word)); // R9
  AST_FLIP_NEEDS_MULTI: assert property (@(posedge clk) disable iff (rst) flip_fire |-> (rd_fire && multi_sel && !fetch_we)); // R6

endmodule

// File: tb/sim_lbuf_token_buffer.sv
`timescale 1ns/1ps
module sim_lbuf_token_buffer;
  localparam int D = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chain_start = 1'b0;
  logic        fetch_we = 1'b0;
  logic [11:0] fetch_word = '0;
  logic        show_en = 1'b0;
  logic [11:0] rd_word;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [11:0] mm [D];
  logic [D-1:0] mt = '0;

  always #10 clk = ~clk;

  lbuf_token_buffer u0 (
    .clk(clk), .rst(rst), .chain_start(chain_start), .fetch_we(fetch_we),
    .fetch_word(fetch_word), .show_en(show_en), .rd_word(rd_word)
  );

  function automatic logic [11:0] pack(input logic [3:0] col, input logic [7:0] ch);
    return {col, ch};
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: rd_word=%03h expected %03h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, model it, compare one cycle later
  task automatic step(input bit s, input bit we, input logic [11:0] d, input bit disp, input string tag);
    logic [11:0] andv;
    logic [11:0] expv;
    int cnt;
    chain_start = s; fetch_we = we; fetch_word = d; show_en = disp;
    andv = 12'hFFF; cnt = 0;
    for (int i = 0; i < D; i++) if (mt[i]) begin andv = andv & mm[i]; cnt++; end
    if (!disp)              expv = 12'hFFF;
    else if (cnt > 0 && we) expv = d;
    else                    expv = andv;
    for (int i = 0; i < D; i++) begin
      if (mt[i]) begin
        if (we) mm[i] = d;
        else if (disp && cnt > 1) mm[i] = andv;
      end
    end
    mt = {mt[D-2:0], 1'b0};
    mt[0] = s;
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_word, expv);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; chain_start = 1'b0; fetch_we = 1'b0; show_en = 1'b0;
    mt = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(tag, rd_word, 12'hFFF);
  endtask

  task automatic readback(input string tag);
    step(1'b1, 1'b0, 12'h000, 1'b1, tag);
    for (int k = 0; k < D; k++) step(1'b0, 1'b0, 12'h000, 1'b1, tag);
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    @(negedge clk);
    do_reset("R10");
    // Nothing selected: write ignored, read returns ones
    step(1'b0, 1'b1, 12'h000, 1'b1, "R7");
    // Fill the row with display dark
    step(1'b1, 1'b0, 12'h000, 1'b0, "R8");
    for (int k = 0; k < D; k++)
      step(1'b0, 1'b1, pack(4'($urandom()), 8'($urandom())), 1'b0, "R8");
    // Clean single-token readback of every word
    readback("R1");
    // Token has left word 39; a write now must not land
    step(1'b0, 1'b1, 12'h000, 1'b1, "R2");
    readback("R7");
    // Second strobe partway through a sweep: AND reads and write-back
    step(1'b1, 1'b0, 12'h000, 1'b1, "R3");
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0, 12'h000, 1'b1, "R5");
    step(1'b1, 1'b0, 12'h000, 1'b1, "R3");
    for (int k = 0; k < D + 2; k++) step(1'b0, 1'b0, 12'h000, 1'b1, "R6");
    readback("R6");
    // Write and display together
    step(1'b1, 1'b1, 12'hA5C, 1'b1, "R9");
    for (int k = 0; k < D; k++)
      step(1'b0, 1'b1, 12'($urandom()), 1'b1, "R9");
    readback("R4");
    // Random mix
    for (int k = 0; k < 600; k++)
      step(($urandom() % 16) == 0, ($urandom() % 4) == 0, 12'($urandom()),
           ($urandom() % 2) == 0, "R3");
    for (int k = 0; k < D + 1; k++) step(1'b0, 1'b0, 12'h000, 1'b0, "R8");
    readback("R6");
    // Reset mid-sweep keeps storage
    step(1'b1, 1'b0, 12'h000, 1'b1, "R10");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 12'h000, 1'b1, "R10");
    do_reset("R10");
    step(1'b0, 1'b1, 12'h000, 1'b1, "R10");
    readback("R10");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule